// File: doc/BRIEF.md
# Hall-Sensor Commutation Controller with Low-Side PWM Chopping

This block turns three Hall-sensor logic levels into the six gate enables of a three-phase bridge. In each of the six valid rotor sectors it picks one phase to source current, with its high-side switch on, and one phase to sink it, with its low-side switch on. The Hall inputs first pass through a synchronizer and a stability filter. The direction input selects between the Hall code and its bitwise complement. The block does not sense any analog quantity. It takes the result of an external duty comparator as `pwm_i`, a peak-current-exceeded flag and a thermal-shutdown flag.

Only the low-side switch is chopped. The high-side switch of the active sector stays on for the whole sector. The peak-current flag cuts the low-side switch and keeps it off until the next rising edge of the PWM signal, which limits the current cycle by cycle. Whenever the decoded sector changes, every low-side switch is held off for a short blanking interval so that the bridge cannot shoot through. The stop input, the thermal flag and the two invalid Hall codes each turn all six switches off. The direction is sampled only while the block is stopped.

Top module: `hall_commutator`

## Requirements
- R1: Hall bits are hall_i[2]=H1, hall_i[1]=H2, hall_i[0]=H3, and output bit 0/1/2 drives phase 1/2/3. In forward direction (direction low) the block drives the following source→sink pairs: 001 gives phase 2→3, 010 gives 1→2, 011 gives 1→3, 100 gives 3→1, 101 gives 2→1, 110 gives 3→2. The source phase's bit is set in hi_en_o and the sink phase's bit is set in lo_en_o.
- R2: In reverse direction (latched direction high) the block decodes the bitwise complement of the Hall code through the R1 table.
- R3: The high-side enable of the active sector stays on whatever pwm_i does. The low-side enable follows pwm_i, high meaning on, one clock later.
- R4: When ilim_i is high, the low-side enables are 0 on the next clock. They stay 0 after ilim_i falls until pwm_i has a rising edge.
- R5: While stop_i is high, all six enables are 0 from the next clock on.
- R6: dir_i is sampled only while stop_i is high. A change of dir_i while the motor runs has no effect.
- R7: While tsd_i is high, all six enables are 0 from the next clock on.
- R8: The accepted Hall codes 000 and 111 are faults and drive all six enables to 0.
- R9: After each change of the decoded sector, all low-side enables stay 0 for BLANK_N clocks (4 by default), counted from the clock on which the new high-side enable appears.
- R10: The Hall inputs pass through a SYNC_N-stage synchronizer (2 by default). A new code is accepted only once it has been stable for STABLE_N clocks (3 by default), so shorter pulses have no effect.
- R11: At most one high-side enable and at most one low-side enable are on at any time, and the high side and the low side of the same phase are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Raw Hall levels {H1,H2,H3} |
| dir_i | input | 1 | Direction, 0 forward, 1 reverse |
| stop_i | input | 1 | 1 stops the motor, all switches off |
| pwm_i | input | 1 | Duty comparator result, 1 = low side may conduct |
| ilim_i | input | 1 | Peak current exceeded |
| tsd_i | input | 1 | Thermal shutdown active |
| hi_en_o | output | 3 | High-side (source) enables, bit n = phase n+1 |
| lo_en_o | output | 3 | Low-side (sink) enables, bit n = phase n+1 |

## Verification
The embedded assertions check on every cycle that the enables stay mutually exclusive and free of shoot-through. They also check that stop, thermal shutdown and the current flag clear the enables one clock later, that a sector change starts a blanking window, that the direction holds while running, and that the filter accepts a code only after its stability count. Only the bench scenarios can show that the sector table is right for all eight codes in both directions. The same holds for the exact blanking length, the rejection of short Hall glitches, and the release of the current limit on the next PWM rising edge.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;
  typedef logic [2:0] phase_t;   // bit n = phase n+1
  localparam int unsigned DEF_SYNC_N   = 2;
  localparam int unsigned DEF_STABLE_N = 3;
  localparam int unsigned DEF_BLANK_N  = 4;
endpackage

// File: rtl/hall_filter.sv
module hall_filter
  import hall_comm_pkg::*;
#(
  parameter int unsigned SYNC_N   = DEF_SYNC_N,
  parameter int unsigned STABLE_N = DEF_STABLE_N
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t hall_i,
  output phase_t hall_o
);
  localparam int unsigned CW = (STABLE_N > 2) ? $clog2(STABLE_N) : 1;
  localparam logic [CW-1:0] CMAX = CW'(STABLE_N - 1);

  phase_t sync_q [SYNC_N];
  phase_t cand_q, acc_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= hall_i;
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  // stability counter: restart on any difference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      cand_q <= sync_q[SYNC_N-1];
      if (sync_q[SYNC_N-1] != cand_q) cnt_q <= '0;
      else if (cnt_q != CMAX)         cnt_q <= cnt_q + 1'b1;
      if (sync_q[SYNC_N-1] == cand_q && cnt_q == CMAX) acc_q <= cand_q;
    end
  end

  assign hall_o = acc_q;

  p_accept_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_q) |-> ($past(cnt_q) == CMAX));
endmodule

// File: rtl/hall_decode.sv
module hall_decode
  import hall_comm_pkg::*;
(
  input  phase_t code_i,
  output phase_t src_o,
  output phase_t snk_o,
  output logic   valid_o
);
  always_comb begin
    valid_o = 1'b1;
    unique case (code_i)
      3'b101:  begin src_o = 3'b010; snk_o = 3'b001; end
      3'b100:  begin src_o = 3'b100; snk_o = 3'b001; end
      3'b110:  begin src_o = 3'b100; snk_o = 3'b010; end
      3'b010:  begin src_o = 3'b001; snk_o = 3'b010; end
      3'b011:  begin src_o = 3'b001; snk_o = 3'b100; end
      3'b001:  begin src_o = 3'b010; snk_o = 3'b100; end
      default: begin src_o = '0; snk_o = '0; valid_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pwm_gate.sv
module pwm_gate
  import hall_comm_pkg::*;
#(
  parameter int unsigned BLANK_N = DEF_BLANK_N
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_t code_i,
  input  phase_t src_i,
  input  phase_t snk_i,
  input  logic   valid_i,
  input  logic   run_i,
  input  logic   pwm_i,
  input  logic   ilim_i,
  output phase_t hi_en_o,
  output phase_t lo_en_o
);
  localparam int unsigned BW = $clog2(BLANK_N + 1);
  localparam logic [BW-1:0] BLOAD = BW'(BLANK_N - 1);

  phase_t        prev_q;
  logic [BW-1:0] blank_q;
  logic          pwm_q, lim_q;
  logic          change, blank, lim_d, en;

  assign change = (code_i != prev_q);
  assign blank  = change || (blank_q != '0);
  // limit holds until the next carrier rising edge; a new trip wins
  assign lim_d  = ilim_i || (lim_q && !(pwm_i && !pwm_q));
  assign en     = run_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      blank_q <= '0;
      pwm_q   <= 1'b0;
      lim_q   <= 1'b0;
      hi_en_o <= '0;
      lo_en_o <= '0;
    end else begin
      prev_q  <= code_i;
      pwm_q   <= pwm_i;
      lim_q   <= lim_d;
      if (change)              blank_q <= BLOAD;
      else if (blank_q != '0)  blank_q <= blank_q - 1'b1;
      hi_en_o <= en ? src_i : '0;
      lo_en_o <= (en && pwm_i && !lim_d && !blank) ? snk_i : '0;
    end
  end

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hi_en_o) && $onehot0(lo_en_o));
  p_no_shoot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en_o & lo_en_o) == '0);
  p_ilim_cut_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |=> lo_en_o == '0);
  p_blank_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change |=> lo_en_o == '0);
  p_pwm_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> lo_en_o == '0);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_comm_pkg::*;
#(
  parameter int unsigned SYNC_N   = DEF_SYNC_N,
  parameter int unsigned STABLE_N = DEF_STABLE_N,
  parameter int unsigned BLANK_N  = DEF_BLANK_N
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       stop_i,
  input  logic       pwm_i,
  input  logic       ilim_i,
  input  logic       tsd_i,
  output logic [2:0] hi_en_o,
  output logic [2:0] lo_en_o
);
  phase_t hall_acc, code, src, snk;
  logic   valid, dir_q;

  hall_filter #(.SYNC_N(SYNC_N), .STABLE_N(STABLE_N)) u_filter (
    .clk_i, .rst_ni, .hall_i, .hall_o(hall_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= 1'b0;
    else if (stop_i) dir_q <= dir_i;
  end

  assign code = hall_acc ^ {3{dir_q}};

  hall_decode u_decode (.code_i(code), .src_o(src), .snk_o(snk), .valid_o(valid));

  pwm_gate #(.BLANK_N(BLANK_N)) u_gate (
    .clk_i, .rst_ni,
    .code_i(code), .src_i(src), .snk_i(snk), .valid_i(valid),
    .run_i(!stop_i && !tsd_i),
    .pwm_i, .ilim_i,
    .hi_en_o, .lo_en_o
  );

  p_dir_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(dir_q));
  p_stop_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (hi_en_o == '0 && lo_en_o == '0));
  p_tsd_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |=> (hi_en_o == '0 && lo_en_o == '0));
endmodule

// File: tb/hall_commutator_bench.sv
module hall_commutator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       dir = 1'b0, stop = 1'b1, pwm = 1'b1, ilim = 1'b0, tsd = 1'b0;
  logic [2:0] hi, lo;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  hall_commutator u_hall_commutator (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .dir_i(dir), .stop_i(stop),
    .pwm_i(pwm), .ilim_i(ilim), .tsd_i(tsd), .hi_en_o(hi), .lo_en_o(lo)
  );

  // expected {src, snk} from the forward table
  function automatic logic [5:0] fwd(input logic [2:0] c);
    case (c)
      3'b001: fwd = {3'b010, 3'b100};
      3'b010: fwd = {3'b001, 3'b010};
      3'b011: fwd = {3'b001, 3'b100};
      3'b100: fwd = {3'b100, 3'b001};
      3'b101: fwd = {3'b010, 3'b001};
      3'b110: fwd = {3'b100, 3'b010};
      default: fwd = 6'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hi/lo %b/%b expected %b/%b", tag, act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic bad;
    step(3);
    chk("R5 reset", {hi, lo}, 6'b0);
    rst_n = 1'b1;
    step(2);
    chk("R5 stopped after reset", {hi, lo}, 6'b0);

    // R1/R2/R8 full sweep, both directions, PWM high and low (R3)
    for (int d = 0; d < 2; d++) begin
      stop = 1'b1; dir = d[0]; step(2);
      stop = 1'b0;
      for (int c = 0; c < 8; c++) begin
        logic [5:0] e;
        hall = c[2:0];
        e = fwd(d[0] ? ~c[2:0] : c[2:0]);
        pwm = 1'b1; step(14);
        chk(d[0] ? "R2 reverse pwm on" : "R1 forward pwm on", {hi, lo}, e);
        pwm = 1'b0; step(2);
        chk("R3 pwm off high side held", {hi, lo}, {e[5:3], 3'b000});
        pwm = 1'b1; step(2);
        chk("R3 pwm back on", {hi, lo}, e);
      end
    end

    // R6: direction change while running is ignored
    stop = 1'b1; dir = 1'b0; step(2); stop = 1'b0;
    hall = 3'b101; step(14);
    chk("R1 101 forward", {hi, lo}, {3'b010, 3'b001});
    dir = 1'b1; step(14);
    chk("R6 dir ignored while running", {hi, lo}, {3'b010, 3'b001});
    stop = 1'b1; step(2);
    chk("R5 stop all off", {hi, lo}, 6'b0);
    stop = 1'b0; step(14);
    chk("R6 dir latched in stop", {hi, lo}, {3'b001, 3'b010});
    stop = 1'b1; dir = 1'b0; step(2); stop = 1'b0; step(14);
    chk("R6 forward relatched", {hi, lo}, {3'b010, 3'b001});

    // R7 thermal shutdown
    tsd = 1'b1; step(2);
    chk("R7 tsd all off", {hi, lo}, 6'b0);
    tsd = 1'b0; step(2);
    chk("R7 tsd released", {hi, lo}, {3'b010, 3'b001});

    // R4 cycle-by-cycle limit
    ilim = 1'b1; step(1);
    chk("R4 ilim cuts sink", {hi, lo}, {3'b010, 3'b000});
    ilim = 1'b0; step(3);
    chk("R4 held until pwm edge", {hi, lo}, {3'b010, 3'b000});
    pwm = 1'b0; step(2);
    pwm = 1'b1; step(1);
    chk("R4 released on pwm rise", {hi, lo}, {3'b010, 3'b001});

    // R9 blanking length after 101 -> 100
    hall = 3'b100;
    n = 0;
    while (hi !== 3'b100 && n < 30) begin step(1); n++; end
    n = 0;
    while (lo === 3'b000 && n < 30) begin n++; step(1); end
    checks++;
    if (n != 4 || lo !== 3'b001) begin
      errors++;
      $display("FAIL R9 blanking: got %0d cycles lo %b expected 4 cycles lo 001", n, lo);
    end

    // R10 two-cycle glitch is ignored
    hall = 3'b110; step(14);
    chk("R1 110 forward", {hi, lo}, {3'b100, 3'b010});
    hall = 3'b010; step(2); hall = 3'b110;
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if ({hi, lo} !== {3'b100, 3'b010}) bad = 1'b1;
    end
    chk("R10 glitch ignored", {hi, lo}, bad ? 6'b111111 : {3'b100, 3'b010});
    hall = 3'b010; step(3);
    chk("R10 not yet accepted", {hi, lo}, {3'b100, 3'b010});
    step(10);
    chk("R10 accepted after stable", {hi, lo}, {3'b001, 3'b010});

    // R8 invalid codes
    hall = 3'b111; step(14);
    chk("R8 code 111 off", {hi, lo}, 6'b0);
    hall = 3'b000; step(14);
    chk("R8 code 000 off", {hi, lo}, 6'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule